// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave, standard mode, that holds a small bank of 8-bit configuration bytes for the control logic around it. Both bus lines are sampled on the system clock. Each line passes through a two-flop synchronizer and then a deglitch counter. Start and stop conditions are decoded from the filtered lines, and the slave pulls SDA low through an open-drain enable. SCL is never held low.

The transfer format is fixed. A write carries three kinds of byte after the address. The first is a command code and the second is a byte count; both are acknowledged and then thrown away. The data bytes follow, and they fill the bank in order from byte 0. A read sends the bank size as a count byte first, then the bytes from byte 0 upward. Once the bank is exhausted, every further byte reads 0xFF. A few bits of the bank are read-only. Some are fixed at their reset level. Two of them follow external status inputs.

The state machine has seven states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address.
- `ST_ACK_ADDR` drives the address acknowledge.
- `ST_WR_BYTE` and `ST_ACK_WR` receive each written byte and acknowledge it.
- `ST_RD_BYTE` shifts a byte out.
- `ST_RD_ACK` samples the master's acknowledge.

The transitions between them are:
- A start from any state goes to `ST_ADDR`.
- A stop from any state goes to `ST_IDLE`.
- At the SCL fall after the eighth address bit, a matching address goes to `ST_ACK_ADDR`. Any other address goes to `ST_IDLE`.
- The SCL fall that ends the acknowledge goes to `ST_WR_BYTE` or `ST_RD_BYTE`, chosen by the direction bit.
- At the SCL fall after eight bits, `ST_WR_BYTE` goes to `ST_ACK_WR`, and `ST_ACK_WR` then goes back to `ST_WR_BYTE` at the next fall.
- At the SCL fall after eight bits, `ST_RD_BYTE` goes to `ST_RD_ACK`.
- In `ST_RD_ACK`, a high SDA at the SCL rise goes to `ST_IDLE`. Otherwise the next SCL fall goes back to `ST_RD_BYTE`.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, `ctrl_out` is 0xFFDF83 when `status_in` is 2'b01: byte 0 is 0x83, byte 1 is 0xFF with bits 5:4 following `status_in`, and byte 2 is 0xFF.
- R2: The slave acknowledges the address byte 0xD2 (write) and the address byte 0xD3 (read). For any other address byte it acknowledges nothing and ignores the bytes that follow until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and have no effect. Each later byte is acknowledged and stored in the next register, starting at byte 0. A register's output changes only while that byte is being acknowledged.
- R4: A stop after any complete data byte ends the write. Bytes already written keep their values, and later bytes keep their previous values.
- R5: A read first returns a count byte equal to the number of registers (3). It then returns byte 0, byte 1 and byte 2, and 0xFF for every byte after those. All bytes are sent MSB first.
- R6: Byte 1 bits 7 and 0 always read 1, and byte 1 bits 5:4 always equal `status_in[1:0]`. Write data has no effect on these bits. Only byte 1 bits 6, 3, 2 and 1 can be written.
- R7: When the master answers a read byte with a not-acknowledge, the read ends and SDA stays released through any further SCL clocks until the next start. SDA is also released on the cycle after a stop.
- R8: A stop or a start received in the middle of a byte abandons that byte and stores nothing from it. After a start, the slave accepts a new address.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT` (3) system clocks is ignored.
- R10: Data bytes written after the last register are acknowledged and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| status_in | input | 2 | Status bits shown in byte 1 bits 5:4 |
| sda_oe | output | 1 | High to pull SDA low (acknowledge or data 0) |
| ctrl_out | output | 24 | Current view of the bank; byte 0 in bits 7:0 |

## Verification
The bench writes and reads the bank while a behavioural model compares `ctrl_out` on every clock. This catches a design that stores the command or count byte, writes one slot off, or updates a register outside its acknowledge. It aborts transfers with a stop and with a start in the middle of a byte. A design that commits a partial byte would change a register there, and one that does not restart on a start would miss the following read address. Reads run past the end of the bank and end with a not-acknowledge, followed by extra SCL clocks. A wrong count, a missing 0xFF fill or a slave that keeps driving SDA then shows up as bad read bytes. Two-clock glitches on both lines are injected inside a data byte. Without the filter, they would add a shifted bit or produce a false start or stop.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WR_BYTE,
        ST_ACK_WR,
        ST_RD_BYTE,
        ST_RD_ACK
    } i2c_state_e;
endpackage

// File: rtl/cfg_i2c_filt.sv
module cfg_i2c_filt #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNTW = $clog2(FILT + 1);

    logic            s1_q, s2_q;
    logic [CNTW-1:0] cnt_q;

    // two-flop synchronizer, idle bus level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    // output follows only after FILT consecutive differing samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout  <= 1'b1;
            cnt_q <= '0;
        end else if (s2_q == dout) begin
            cnt_q <= '0;
        end else if (cnt_q == CNTW'(FILT - 1)) begin
            dout  <= s2_q;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNTW'(1);
        end
    end
endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs #(
    parameter int                NREG     = 3,
    parameter int                IW       = 2,
    parameter logic [NREG*8-1:0] RST_VAL  = 24'hFFFF83,
    parameter logic [NREG*8-1:0] RW_MASK  = 24'hFF4EFF,
    parameter int                STAT_REG = 1,
    parameter int                STAT_LSB = 4,
    parameter int                STAT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [STAT_W-1:0] status_in,
    input  logic [IW-1:0]     rd_idx,
    output logic [7:0]        rd_data,
    output logic [NREG*8-1:0] view
);
    localparam logic [7:0] SMASK = ((8'd1 << STAT_W) - 8'd1) << STAT_LSB;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] MASK = RW_MASK[g*8 +: 8];
        localparam logic [7:0] DEF  = RST_VAL[g*8 +: 8];
        logic [7:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= DEF;
            else if (wr_en && wr_idx == IW'(g))
                q <= (wr_data & MASK) | (q & ~MASK);
        end

        if (g == STAT_REG) begin : g_stat
            assign view[g*8 +: 8] = (q & ~SMASK)
                                  | (8'({{(8-STAT_W){1'b0}}, status_in}) << STAT_LSB);
        end else begin : g_plain
            assign view[g*8 +: 8] = q;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREG; i++)
            if (rd_idx == IW'(i)) rd_data = view[i*8 +: 8];
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
    import cfg_i2c_pkg::*;
#(
    parameter int                NREG     = 3,
    parameter int                FILT     = 3,
    parameter logic [6:0]        DEV_ADDR = 7'h69,
    parameter logic [NREG*8-1:0] RST_VAL  = 24'hFFFF83,
    parameter logic [NREG*8-1:0] RW_MASK  = 24'hFF4EFF,
    parameter int                STAT_REG = 1,
    parameter int                STAT_LSB = 4,
    parameter int                STAT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [STAT_W-1:0] status_in,
    output logic              sda_oe,
    output logic [NREG*8-1:0] ctrl_out
);
    localparam int IW = $clog2(NREG + 1);
    localparam int CW = $clog2(NREG + 3);

    i2c_state_e state_q, state_d;
    logic       scl_f, sda_f, scl_p, sda_p;
    logic       scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, tx_q, rd_data;
    logic       rnw_q, wr_en, rx_state;
    logic [CW-1:0] wr_cnt_q;
    logic [IW-1:0] rd_idx_q, wr_idx;

    cfg_i2c_filt #(.FILT(FILT)) u_scl (.clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));
    cfg_i2c_filt #(.FILT(FILT)) u_sda (.clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
    assign rx_state = (state_q == ST_ADDR) || (state_q == ST_WR_BYTE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_ev)
            state_d = ST_ADDR;
        else if (stop_ev)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (scl_fall && bitcnt_q == 4'd8)
                                 state_d = (shreg_q[7:1] == DEV_ADDR) ? ST_ACK_ADDR : ST_IDLE;
                ST_ACK_ADDR: if (scl_fall) state_d = rnw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bitcnt_q == 4'd8) state_d = ST_ACK_WR;
                ST_ACK_WR:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt_q == 4'd7) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise && sda_f) state_d = ST_IDLE;
                             else if (scl_fall) state_d = ST_RD_BYTE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // byte commit: first two bytes after the address are discarded
    assign wr_en  = (state_q == ST_WR_BYTE) && (state_d == ST_ACK_WR)
                 && (wr_cnt_q >= CW'(2)) && (wr_cnt_q < CW'(NREG + 2));
    assign wr_idx = IW'(wr_cnt_q - CW'(2));

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            tx_q     <= '0;
            rnw_q    <= 1'b0;
            wr_cnt_q <= '0;
            rd_idx_q <= '0;
        end else begin
            if (start_ev || state_d != state_q)
                bitcnt_q <= '0;
            else if ((scl_rise && rx_state) || (scl_fall && state_q == ST_RD_BYTE))
                bitcnt_q <= bitcnt_q + 4'd1;

            if (scl_rise && rx_state)
                shreg_q <= {shreg_q[6:0], sda_f};

            if (state_q == ST_ADDR && state_d == ST_ACK_ADDR)
                rnw_q <= shreg_q[0];

            if (state_q == ST_ACK_ADDR && state_d == ST_WR_BYTE)
                wr_cnt_q <= '0;
            else if (state_q == ST_WR_BYTE && state_d == ST_ACK_WR && wr_cnt_q < CW'(NREG + 2))
                wr_cnt_q <= wr_cnt_q + CW'(1);

            if (state_q == ST_ACK_ADDR && state_d == ST_RD_BYTE) begin
                tx_q     <= 8'(NREG);
                rd_idx_q <= '0;
            end else if (state_q == ST_RD_ACK && state_d == ST_RD_BYTE) begin
                tx_q <= rd_data;
                if (rd_idx_q < IW'(NREG)) rd_idx_q <= rd_idx_q + IW'(1);
            end else if (state_q == ST_RD_BYTE && scl_fall) begin
                tx_q <= {tx_q[6:0], 1'b1};
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACK_ADDR, ST_ACK_WR: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_q[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    cfg_i2c_regs #(
        .NREG(NREG), .IW(IW), .RST_VAL(RST_VAL), .RW_MASK(RW_MASK),
        .STAT_REG(STAT_REG), .STAT_LSB(STAT_LSB), .STAT_W(STAT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(shreg_q),
        .status_in(status_in), .rd_idx(rd_idx_q), .rd_data(rd_data), .view(ctrl_out)
    );
endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker
    import cfg_i2c_pkg::*;
#(
    parameter int                NREG     = 3,
    parameter logic [NREG*8-1:0] RST_VAL  = 24'hFFFF83,
    parameter logic [NREG*8-1:0] RW_MASK  = 24'hFF4EFF,
    parameter int                STAT_REG = 1,
    parameter int                STAT_LSB = 4,
    parameter int                STAT_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic              stop_ev,
    input i2c_state_e        state_q,
    input logic [STAT_W-1:0] status_in,
    input logic [NREG*8-1:0] ctrl_out
);
    localparam int            W      = NREG * 8;
    localparam logic [W-1:0] SFIELD = ((W'(1) << STAT_W) - W'(1)) << (STAT_REG * 8 + STAT_LSB);
    localparam logic [W-1:0] NSTAT  = ~SFIELD;

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((ctrl_out & NSTAT) == (RST_VAL & NSTAT))); // R1
    AST_ACK_DRIVE_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q inside {ST_ACK_ADDR, ST_ACK_WR, ST_RD_BYTE})); // R2
    AST_WRITE_AT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_out & RW_MASK) != ($past(ctrl_out) & RW_MASK)) |-> (state_q == ST_ACK_WR)); // R3
    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_out[STAT_REG*8+STAT_LSB +: STAT_W] == status_in); // R6
    AST_RO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_out & ~RW_MASK & NSTAT) == (RST_VAL & ~RW_MASK & NSTAT)); // R6
    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe); // R7
endmodule

bind cfg_i2c_slave cfg_i2c_checker #(
    .NREG(NREG), .RST_VAL(RST_VAL), .RW_MASK(RW_MASK),
    .STAT_REG(STAT_REG), .STAT_LSB(STAT_LSB), .STAT_W(STAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .stop_ev(stop_ev),
    .state_q(state_q), .status_in(status_in), .ctrl_out(ctrl_out)
);

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 20;

    logic        clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0]  status = 2'b01;
    logic        sda_oe;
    logic [23:0] ctrl_out;
    logic        sda_line;
    int          checks = 0, errors = 0;
    bit          cmp_en = 1'b0;
    logic [7:0]  mreg [3];

    assign sda_line = m_sda & ~sda_oe;
    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                      .status_in(status), .sda_oe(sda_oe), .ctrl_out(ctrl_out));

    function automatic logic [7:0] view(int i);
        logic [7:0] v;
        if (i > 2) return 8'hFF;
        v = mreg[i];
        if (i == 1) begin v[7] = 1'b1; v[0] = 1'b1; v[5:4] = status; end
        return v;
    endfunction

    function automatic logic [23:0] view_all();
        return {view(2), view(1), view(0)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(int slot, logic [7:0] d);
        if (slot == 1) mreg[1] = (mreg[1] & ~8'h4E) | (d & 8'h4E);
        else if (slot == 0 || slot == 2) mreg[slot] = d;
    endtask

    // every clock: the bank view must match the model (R3, R4, R6, R8)
    always @(negedge clk) if (cmp_en) check("R3 bank view", ctrl_out, view_all());

    task automatic wq(int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(logic [7:0] b, int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq();
        end
    endtask

    // slot >= 0: data slot for the model; glitch: inject short pulses in bit 4
    task automatic send_byte(logic [7:0] b, int slot, bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            if (glitch && i == 4) begin
                repeat (5) @(negedge clk); m_scl = 1'b1;
                repeat (2) @(negedge clk); m_scl = 1'b0;
            end
            wq(); m_scl = 1'b1;
            if (glitch && i == 4) begin
                repeat (5) @(negedge clk); m_sda = ~b[i];
                repeat (2) @(negedge clk); m_sda = b[i];
            end
            wq(2);
            if (i == 0) cmp_en = 1'b0;
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1;
        model_write(slot, b);
        cmp_en = 1'b1;
        wq(); m_scl = 1'b1; wq(); ack = !sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit mack);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); b[i] = sda_line; wq(); m_scl = 1'b0;
        end
        wq(); m_sda = !mack; wq(); m_scl = 1'b1; wq(2); m_scl = 1'b0; wq(); m_sda = 1'b1;
    endtask

    task automatic write_seq(logic [7:0] d[$], bit glitch);
        bit ack;
        i2c_start();
        send_byte(8'hD2, -1, 1'b0, ack); check("R2 write address ack", ack, 1);
        send_byte(8'h5A, -1, 1'b0, ack); check("R3 command ack", ack, 1);
        send_byte(8'h96, -1, 1'b0, ack); check("R3 count ack", ack, 1);
        foreach (d[k]) begin
            send_byte(d[k], k, glitch, ack);
            check(k > 2 ? "R10 surplus data ack" : "R3 data ack", ack, 1);
        end
        i2c_stop();
    endtask

    task automatic read_seq(int n);
        bit ack; logic [7:0] b;
        i2c_start();
        send_byte(8'hD3, -1, 1'b0, ack); check("R2 read address ack", ack, 1);
        recv_byte(b, 1'b1); check("R5 count byte", b, 3);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            check(i > 2 ? "R5 fill byte" : "R5 data byte", b, view(i));
        end
        // R7: after the not-acknowledge the line stays released
        for (int k = 0; k < 9; k++) begin
            wq(); m_scl = 1'b1; wq(); check("R7 released after nack", sda_line, 1); wq(); m_scl = 1'b0; wq();
        end
        i2c_stop();
    endtask

    initial begin
        bit ack; logic [7:0] b;
        mreg[0] = 8'h83; mreg[1] = 8'hFF; mreg[2] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1 released during reset", sda_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset view", ctrl_out, 24'hFFDF83);
        cmp_en = 1'b1;
        read_seq(3);
        write_seq('{8'hA5, 8'h00, 8'h3C, 8'h77}, 1'b0);       // R3 R10 R6
        check("R6 byte 1 after clearing write", ctrl_out[15:8], 8'h91);
        read_seq(5);                                           // R5 fill past end
        // R2: foreign address gets no acknowledge and no effect
        i2c_start();
        send_byte(8'hA4, -1, 1'b0, ack); check("R2 foreign address nack", ack, 0);
        send_byte(8'h00, -1, 1'b0, ack); check("R2 ignored after foreign", ack, 0);
        i2c_stop();
        // R4: stop after one data byte leaves bytes 1 and 2 alone
        write_seq('{8'h11}, 1'b0);
        check("R4 partial write", ctrl_out, {view(2), view(1), 8'h11});
        // R8: stop mid-byte
        i2c_start();
        send_byte(8'hD2, -1, 1'b0, ack); send_byte(8'h00, -1, 1'b0, ack);
        send_byte(8'h00, -1, 1'b0, ack);
        send_bits(8'hF0, 4);
        i2c_stop();
        check("R8 stop mid-byte keeps byte 0", ctrl_out[7:0], 8'h11);
        // R8: start mid-byte then read
        i2c_start();
        send_byte(8'hD2, -1, 1'b0, ack); send_byte(8'h00, -1, 1'b0, ack);
        send_byte(8'h00, -1, 1'b0, ack);
        send_bits(8'h00, 5);
        i2c_start();
        send_byte(8'hD3, -1, 1'b0, ack); check("R8 address after restart", ack, 1);
        recv_byte(b, 1'b1); check("R8 count after restart", b, 3);
        recv_byte(b, 1'b0); check("R8 byte 0 untouched", b, 8'h11);
        i2c_stop();
        // R9: glitches on both lines inside data bytes
        write_seq('{8'hC3, 8'hFF, 8'h5A}, 1'b1);
        check("R9 glitched write", ctrl_out, {8'h5A, view(1), 8'hC3});
        // R6: status input change, writes do not touch read-only bits
        status = 2'b10;
        repeat (2) @(negedge clk);
        check("R6 status follows", ctrl_out[15:8], 8'hEF);
        read_seq(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule